// File: doc/BRIEF.md
# Stereo Record-Then-Playback Sequencer

This block first records a fixed run of stereo sample pairs into a synchronous single-port RAM and then plays the same run back out. Pacing comes from a level frame-sync flag. Before it handles a frame, the block waits for the flag to be low and then for it to be high again. So at most one stereo pair is handled per frame, however long the flag stays high.

During recording, the received left and right words are latched at the frame edge. They pass through a zero-latency identity hook, which is a placeholder for later sample processing. They are then written to two consecutive addresses, left first, starting at `START_ADDR`. Recording stops once the write pointer is no longer below `END_ADDR`. The pointer then reloads to `START_ADDR` and playback begins.

Playback reads one pair per frame and updates four transmit slots together: left, right, and two slots that carry a constant control word. When the read pointer reaches `END_ADDR` the sequencer parks in an idle state. A `start` pulse re-arms it for another record pass.

States and transitions:
- After reset the block is in `ST_REC_LOW`.
- `ST_REC_LOW` moves to `ST_REC_HIGH` when the flag is low.
- `ST_REC_HIGH` moves to `ST_REC_WL` when the flag is high. This cycle also latches the received pair.
- `ST_REC_WL` moves to `ST_REC_WR`, which moves to `ST_REC_CHK`.
- `ST_REC_CHK` returns to `ST_REC_LOW` while the pointer is below the end. Otherwise it reloads the pointer and moves to `ST_PLAY_LOW`.
- `ST_PLAY_LOW` moves to `ST_PLAY_HIGH`, using the same flag conditions as recording.
- `ST_PLAY_HIGH` moves to `ST_PLAY_RL`, which moves to `ST_PLAY_RR`, which moves to `ST_PLAY_LOAD`.
- `ST_PLAY_LOAD` returns to `ST_PLAY_LOW` while the pointer is below the end. Otherwise it moves to `ST_IDLE`.
- `ST_IDLE` moves to `ST_REC_LOW` on `start`, and the pointer reloads.

`END_ADDR - START_ADDR` must be a nonzero even number.

Top module: `srps_top`

## Requirements
- R1: A record pass writes exactly the addresses `START_ADDR` up to `END_ADDR-1`, in increasing order. In each frame the left word goes to the lower address and the right word to the next one. No write falls outside that range.
- R2: A pair is captured only after the frame-sync flag has been seen low and then high. Holding the flag high for many cycles captures no second pair. The values stored are those present on `rx_left`/`rx_right` in the cycle the high level is detected.
- R3: After the last pair is recorded, playback starts again from `START_ADDR`. Each frame presents one stored pair, with the left word on `tx_slot0` and the right word on `tx_slot1`. Pairs come out in recorded order.
- R4: `tx_slot2` and `tx_slot3` are zero from reset until the first playback update. From then on they carry `CTRL_WORD`.
- R5: Once the read pointer reaches `END_ADDR`, `done` is high and stays high. The RAM is not accessed, and further frames leave all transmit slots unchanged.
- R6: A `start` pulse while `done` is high begins a new record pass from `START_ADDR`. A `start` pulse while `done` is low has no effect on the address sequence.
- R7: Reset puts the block in record-arm state: `done` low, `mem_en` low, `tx_strobe` low and all four slots zero.
- R8: `tx_strobe` is a single-cycle pulse. It rises once per played pair, in the cycle the new slot values appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Re-arm pulse, honoured only while idle |
| fs_flag | input | 1 | Frame-sync level flag |
| rx_left | input | DATA_W | Received left word |
| rx_right | input | DATA_W | Received right word |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (1 = write) |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after a read access |
| tx_slot0 | output | DATA_W | Transmit slot 0: left sample |
| tx_slot1 | output | DATA_W | Transmit slot 1: right sample |
| tx_slot2 | output | DATA_W | Transmit slot 2: control word |
| tx_slot3 | output | DATA_W | Transmit slot 3: control word |
| tx_strobe | output | 1 | Pulse when the slots take a new pair |
| done | output | 1 | High while idle |

## Verification
The bench holds the frame flag high for a long stretch mid-record. A design that detected level rather than a low-then-high sequence would write extra pairs and shift every later address. It pulses `start` during recording, which a design that re-armed from any state would answer by jumping back to `START_ADDR`. It also compares each played pair with the stored one, which catches an off-by-one in the read-data pipeline: that fault would show the previous pair or swap left and right. Finally, it keeps frames running after the end. A sequencer that failed to park would touch the RAM again or change the slots, and the bench checks the full record-play-idle-restart cycle twice with different data.

// File: rtl/srps_pkg.sv
package srps_pkg;

    typedef enum logic [3:0] {
        ST_REC_LOW,
        ST_REC_HIGH,
        ST_REC_WL,
        ST_REC_WR,
        ST_REC_CHK,
        ST_PLAY_LOW,
        ST_PLAY_HIGH,
        ST_PLAY_RL,
        ST_PLAY_RR,
        ST_PLAY_LOAD,
        ST_IDLE
    } seq_state_t;

    localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/srps_hook.sv
module srps_hook #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned LANES  = 2
) (
    input  logic [LANES-1:0][DATA_W-1:0] lane_in,
    output logic [LANES-1:0][DATA_W-1:0] lane_out
);

    // Zero-latency identity stage; a later processing step slots in here.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_out[g] = lane_in[g];
    end

endmodule

// File: rtl/srps_ptr.sv
module srps_ptr #(
    parameter int unsigned           ADDR_W     = 24,
    parameter logic [ADDR_W-1:0]     START_ADDR = '0,
    parameter logic [ADDR_W-1:0]     END_ADDR   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic              below_end
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= START_ADDR;
        end else if (reload) begin
            ptr <= START_ADDR;
        end else if (step) begin
            ptr <= ptr + ONE;
        end
    end

    assign below_end = (ptr < END_ADDR);

endmodule

// File: rtl/srps_tx_bank.sv
module srps_tx_bank #(
    parameter int unsigned       DATA_W    = 24,
    parameter logic [DATA_W-1:0] CTRL_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    output logic [DATA_W-1:0] slot0,
    output logic [DATA_W-1:0] slot1,
    output logic [DATA_W-1:0] slot2,
    output logic [DATA_W-1:0] slot3,
    output logic              strobe
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0  <= '0;
            slot1  <= '0;
            slot2  <= '0;
            slot3  <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= load;
            if (load) begin
                slot0 <= left_in;
                slot1 <= right_in;
                slot2 <= CTRL_WORD;
                slot3 <= CTRL_WORD;
            end
        end
    end

endmodule

// File: rtl/srps_top.sv
module srps_top
    import srps_pkg::*;
#(
    parameter int unsigned       DATA_W     = 24,
    parameter int unsigned       ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] START_ADDR = 24'h040000,
    parameter logic [ADDR_W-1:0] END_ADDR   = 24'h050000,
    parameter logic [DATA_W-1:0] CTRL_WORD  = 24'h000300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fs_flag,
    input  logic [DATA_W-1:0] rx_left,
    input  logic [DATA_W-1:0] rx_right,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] tx_slot0,
    output logic [DATA_W-1:0] tx_slot1,
    output logic [DATA_W-1:0] tx_slot2,
    output logic [DATA_W-1:0] tx_slot3,
    output logic              tx_strobe,
    output logic              done
);

    localparam int unsigned LANE_L = 0;
    localparam int unsigned LANE_R = 1;

    seq_state_t state_q, state_d;

    logic [NUM_LANES-1:0][DATA_W-1:0] cap_q;
    logic [NUM_LANES-1:0][DATA_W-1:0] hooked;
    logic [DATA_W-1:0]                rd_left_q;

    logic              ptr_reload;
    logic              ptr_step;
    logic              ptr_below;
    logic [ADDR_W-1:0] ptr;
    logic              bank_load;
    logic              cap_take;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REC_LOW:   if (!fs_flag) state_d = ST_REC_HIGH;
            ST_REC_HIGH:  if (fs_flag)  state_d = ST_REC_WL;
            ST_REC_WL:    state_d = ST_REC_WR;
            ST_REC_WR:    state_d = ST_REC_CHK;
            ST_REC_CHK:   state_d = ptr_below ? ST_REC_LOW : ST_PLAY_LOW;
            ST_PLAY_LOW:  if (!fs_flag) state_d = ST_PLAY_HIGH;
            ST_PLAY_HIGH: if (fs_flag)  state_d = ST_PLAY_RL;
            ST_PLAY_RL:   state_d = ST_PLAY_RR;
            ST_PLAY_RR:   state_d = ST_PLAY_LOAD;
            ST_PLAY_LOAD: state_d = ptr_below ? ST_PLAY_LOW : ST_IDLE;
            ST_IDLE:      if (start) state_d = ST_REC_LOW;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_REC_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        ptr_step   = 1'b0;
        ptr_reload = 1'b0;
        bank_load  = 1'b0;
        cap_take   = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_REC_HIGH: begin
                cap_take = fs_flag;
            end
            ST_REC_WL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hooked[LANE_L];
                ptr_step  = 1'b1;
            end
            ST_REC_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hooked[LANE_R];
                ptr_step  = 1'b1;
            end
            ST_REC_CHK: begin
                ptr_reload = !ptr_below;
            end
            ST_PLAY_RL, ST_PLAY_RR: begin
                mem_en   = 1'b1;
                ptr_step = 1'b1;
            end
            ST_PLAY_LOAD: begin
                bank_load = 1'b1;
            end
            ST_IDLE: begin
                done       = 1'b1;
                ptr_reload = start;
            end
            default: begin
            end
        endcase
    end

    assign mem_addr = ptr;

    // Receive latch at the frame edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_take) begin
            cap_q[LANE_L] <= rx_left;
            cap_q[LANE_R] <= rx_right;
        end
    end

    // Left read word arrives while the right read is issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_left_q <= '0;
        end else if (state_q == ST_PLAY_RR) begin
            rd_left_q <= mem_rdata;
        end
    end

    srps_hook #(
        .DATA_W (DATA_W),
        .LANES  (NUM_LANES)
    ) u_hook (
        .lane_in  (cap_q),
        .lane_out (hooked)
    );

    srps_ptr #(
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR),
        .END_ADDR   (END_ADDR)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (ptr_reload),
        .step      (ptr_step),
        .ptr       (ptr),
        .below_end (ptr_below)
    );

    srps_tx_bank #(
        .DATA_W    (DATA_W),
        .CTRL_WORD (CTRL_WORD)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bank_load),
        .left_in  (rd_left_q),
        .right_in (mem_rdata),
        .slot0    (tx_slot0),
        .slot1    (tx_slot1),
        .slot2    (tx_slot2),
        .slot3    (tx_slot3),
        .strobe   (tx_strobe)
    );

endmodule

// File: rtl/srps_chk.sv
module srps_chk #(
    parameter int unsigned       DATA_W     = 24,
    parameter int unsigned       ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] START_ADDR = 24'h040000,
    parameter logic [ADDR_W-1:0] END_ADDR   = 24'h050000,
    parameter logic [DATA_W-1:0] CTRL_WORD  = 24'h000300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] tx_slot2,
    input logic [DATA_W-1:0] tx_slot3,
    input logic              tx_strobe,
    input logic              done
);

    // R1: every write stays inside the record window
    p_write_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_addr >= START_ADDR && mem_addr < END_ADDR));

    // R1: back-to-back writes step the address by one
    p_write_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && $past(mem_en && mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R8: strobe lasts one cycle
    p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);

    // R4: after a playback update the control slots hold the constant
    p_ctrl_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> (tx_slot2 == CTRL_WORD && tx_slot3 == CTRL_WORD));

    // R5: no memory traffic while idle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en);

    // R5: idle persists without start
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R6: start while idle re-arms
    p_idle_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

endmodule

bind srps_top srps_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR),
    .END_ADDR   (END_ADDR),
    .CTRL_WORD  (CTRL_WORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .tx_slot2  (tx_slot2),
    .tx_slot3  (tx_slot3),
    .tx_strobe (tx_strobe),
    .done      (done)
);

// File: tb/sim_srps_top.sv
`timescale 1ns/1ps
module sim_srps_top;

    localparam int unsigned       DW    = 16;
    localparam int unsigned       AW    = 8;
    localparam logic [AW-1:0]     S_ADR = 8'h10;
    localparam logic [AW-1:0]     E_ADR = 8'h18;
    localparam logic [DW-1:0]     CW    = 16'h0300;
    localparam int                PAIRS = (E_ADR - S_ADR) / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          fs_flag = 1'b0;
    logic [DW-1:0] rx_left = '0;
    logic [DW-1:0] rx_right = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] tx_slot0, tx_slot1, tx_slot2, tx_slot3;
    logic          tx_strobe, done;

    logic [DW-1:0] ram [0:255];

    integer checks = 0;
    integer errors = 0;
    integer writes = 0;
    integer strobes = 0;
    integer idle_access = 0;
    logic [AW-1:0] exp_wa = S_ADR;
    logic          track_idle = 1'b0;

    always #10 clk = ~clk;

    srps_top #(
        .DATA_W(DW), .ADDR_W(AW), .START_ADDR(S_ADR), .END_ADDR(E_ADR), .CTRL_WORD(CW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fs_flag(fs_flag),
        .rx_left(rx_left), .rx_right(rx_right),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_slot0(tx_slot0), .tx_slot1(tx_slot1), .tx_slot2(tx_slot2), .tx_slot3(tx_slot3),
        .tx_strobe(tx_strobe), .done(done)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench RAM model and write-address monitor
    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            ram[mem_addr] <= mem_wdata;
            writes = writes + 1;
            check(mem_addr == exp_wa, "R1/R6 write address", mem_addr, exp_wa);
            exp_wa = exp_wa + 1'b1;
        end
        if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
        if (tx_strobe) strobes = strobes + 1;
        if (track_idle && mem_en) idle_access = idle_access + 1;
    end

    function automatic logic [DW-1:0] pat_l(input int p, input int k);
        return DW'((p << 12) | (k << 4) | 1);
    endfunction
    function automatic logic [DW-1:0] pat_r(input int p, input int k);
        return DW'((p << 12) | (k << 4) | 2);
    endfunction

    task automatic frame(input logic [DW-1:0] l, input logic [DW-1:0] r, input int hi_len);
        @(negedge clk);
        rx_left = l; rx_right = r; fs_flag = 1'b0;
        repeat (3) @(negedge clk);
        fs_flag = 1'b1;
        repeat (hi_len) @(negedge clk);
        rx_left = ~l; rx_right = ~r;
        @(negedge clk);
    endtask

    task automatic run_pass(input int p, input bit mid_start, input bit long_high);
        int w0;
        w0 = writes;
        for (int k = 0; k < PAIRS; k++) begin
            frame(pat_l(p, k), pat_r(p, k), (long_high && k == 1) ? 40 : 6);
            if (mid_start && k == 0) begin
                @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
                check(done == 1'b0, "R6 start ignored when busy", done, 0);
            end
            check(tx_slot2 == '0 && tx_slot3 == '0 || p > 0, "R4 control slots zero before playback", tx_slot2, 0);
        end
        check(writes - w0 == 2 * PAIRS, "R2 one pair per frame", writes - w0, 2 * PAIRS);
        for (int a = 0; a < 2 * PAIRS; a++) begin
            logic [DW-1:0] e;
            e = (a % 2 == 0) ? pat_l(p, a / 2) : pat_r(p, a / 2);
            check(ram[S_ADR + a] == e, "R1/R2 stored word", ram[S_ADR + a], e);
        end
        for (int k = 0; k < PAIRS; k++) begin
            int s0;
            s0 = strobes;
            check(done == 1'b0, "R5 not idle during playback", done, 0);
            frame(16'hDEAD, 16'hBEEF, 6);
            check(tx_slot0 == pat_l(p, k), "R3 left slot", tx_slot0, pat_l(p, k));
            check(tx_slot1 == pat_r(p, k), "R3 right slot", tx_slot1, pat_r(p, k));
            check(tx_slot2 == CW && tx_slot3 == CW, "R4 control slots", tx_slot2, CW);
            check(strobes - s0 == 1, "R8 one strobe per pair", strobes - s0, 1);
        end
        check(done == 1'b1, "R5 idle after playback", done, 1);
        track_idle = 1'b1;
        frame(16'h1111, 16'h2222, 6);
        frame(16'h3333, 16'h4444, 6);
        check(done == 1'b1, "R5 idle holds", done, 1);
        check(idle_access == 0, "R5 no RAM access in idle", idle_access, 0);
        check(tx_slot0 == pat_l(p, PAIRS - 1) && tx_slot1 == pat_r(p, PAIRS - 1),
              "R5 slots frozen in idle", tx_slot0, pat_l(p, PAIRS - 1));
        track_idle = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R7 done low after reset", done, 0);
        check(mem_en == 1'b0, "R7 no access after reset", mem_en, 0);
        check(tx_strobe == 1'b0, "R7 strobe low after reset", tx_strobe, 0);
        check(tx_slot0 == '0 && tx_slot1 == '0 && tx_slot2 == '0 && tx_slot3 == '0,
              "R7 slots zero after reset", tx_slot0, 0);
        exp_wa = S_ADR;
        run_pass(0, 1'b1, 1'b1);
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        check(done == 1'b0, "R6 start re-arms from idle", done, 0);
        exp_wa = S_ADR;
        run_pass(1, 1'b0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule